// File: doc/BRIEF.md
# Hierarchical Word-Addressed RAM

A single-port random-access memory of 16-bit words whose depth is set by the address width parameter. Any word can be read at any time: the output is a combinational function of the address and the stored contents, so a reader sets the address and samples the data in the same cycle. A write happens on the rising clock edge when the load strobe is high. It replaces only the addressed word, and the new value shows on the output from the following cycle.

Storage is assembled recursively. The leaf is an 8-word bank. Each level above it splits the address into two parts. The most significant part picks a sub-array and steers the write strobe to it. The remaining low bits go to every sub-array in parallel, and the same upper part drives the read multiplexer. Supported depths are 8, 64, 512, 4096 and 16384 words, with 3, 6, 9, 12 and 14 address bits. Most levels use a 3-bit selector and fan out to eight sub-arrays. When the address width is not a multiple of three, the top level uses a narrower selector. For 14 bits that selector is 2 bits wide and fans out to four 4096-word sub-arrays.

Top module: `hier_ram`

## Requirements
- R1: The array holds 2^ADDR_W words of 16 bits each. Every word keeps its own value, so filling all addresses with distinct data and reading them back returns each value unchanged.
- R2: The first address (0) and the last address (2^ADDR_W-1) are separate, fully usable words.
- R3: On a clock edge with load_i low, no stored word changes.
- R4: On a clock edge with load_i high, the word at addr_i takes wdata_i and every other word keeps its value.
- R5: A written value appears on rdata_o from the cycle after the write edge. During the write cycle itself, rdata_o still shows the old content of the addressed word.
- R6: rdata_o follows addr_i combinationally. A change of address within a cycle, with no clock edge, changes the output to the content of the new word.
- R7: Addresses that differ only in the top-level selector bits (the most significant bits) are distinct words, and so are addresses that differ only in the low bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Write clock, rising edge |
| load_i | input | 1 | Write strobe, 1 = write wdata_i at addr_i on this edge |
| addr_i | input | ADDR_W | Word address for both read and write |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Content of the word at addr_i |

## Verification
The storage has no reset, so the assertions assume the inputs are known and stable at every clock edge. They also ignore the edge before the first one, when nothing has been sampled yet. The bench changes inputs only on falling edges. It reads from the array only after writing there, so its model never has to predict a word that has never been loaded. The random phase uses a fixed linear congruential sequence and forces the first and last addresses often, so the boundary words see both reads and writes.

// File: rtl/ram_pkg.sv
`timescale 1ns/1ps
package ram_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned BANK_AW = 3;  // leaf bank address width (8 words)
endpackage

// File: rtl/ram_bank8.sv
`timescale 1ns/1ps
module ram_bank8 #(
  parameter int unsigned AW     = ram_pkg::BANK_AW,
  parameter int unsigned DATA_W = ram_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned WORDS = 1 << AW;

  logic [WORDS-1:0][DATA_W-1:0] mem_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];

  logic primed_q = 1'b0;
  always_ff @(posedge clk_i) primed_q <= 1'b1;

  assert_bank_hold_R3: assert property (@(posedge clk_i) disable iff (!primed_q)
    !we_i |=> mem_q == $past(mem_q));

  assert_bank_write_R4: assert property (@(posedge clk_i) disable iff (!primed_q)
    we_i |=> mem_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/ram_wr_decode.sv
`timescale 1ns/1ps
module ram_wr_decode #(
  parameter int unsigned SEL_W = 3
) (
  input  logic               we_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [(1<<SEL_W)-1:0] we_o
);
  localparam int unsigned NSUB = 1 << SEL_W;

  for (genvar g = 0; g < NSUB; g++) begin : g_dec
    assign we_o[g] = we_i && (sel_i == SEL_W'(g));
  end

  always_comb begin
    assert_dec_onehot_R4: assert ($onehot0(we_o));
    if (we_i) begin
      assert_dec_single_R4: assert ($countones(we_o) == 1);
    end
  end
endmodule

// File: rtl/ram_node.sv
`timescale 1ns/1ps
module ram_node #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = ram_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned BANK_AW = ram_pkg::BANK_AW;

  if (ADDR_W <= BANK_AW) begin : g_leaf
    ram_bank8 #(.AW(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk_i  (clk_i),
      .we_i   (we_i),
      .addr_i (addr_i),
      .wdata_i(wdata_i),
      .rdata_o(rdata_o)
    );
  end else begin : g_split
    // narrow top selector when width is not a multiple of the bank width
    localparam int unsigned SEL_W = (ADDR_W % BANK_AW == 0) ? BANK_AW : (ADDR_W % BANK_AW);
    localparam int unsigned SUB_W = ADDR_W - SEL_W;
    localparam int unsigned NSUB  = 1 << SEL_W;

    logic [SEL_W-1:0]             sel;
    logic [SUB_W-1:0]             low;
    logic [NSUB-1:0]              sub_we;
    logic [NSUB-1:0][DATA_W-1:0]  sub_rd;

    assign sel = addr_i[ADDR_W-1:SUB_W];
    assign low = addr_i[SUB_W-1:0];

    ram_wr_decode #(.SEL_W(SEL_W)) u_dec (
      .we_i (we_i),
      .sel_i(sel),
      .we_o (sub_we)
    );

    for (genvar s = 0; s < NSUB; s++) begin : g_sub
      ram_node #(.ADDR_W(SUB_W), .DATA_W(DATA_W)) u_sub (
        .clk_i  (clk_i),
        .we_i   (sub_we[s]),
        .addr_i (low),
        .wdata_i(wdata_i),
        .rdata_o(sub_rd[s])
      );
    end

    assign rdata_o = sub_rd[sel];
  end
endmodule

// File: rtl/hier_ram.sv
`timescale 1ns/1ps
module hier_ram #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = ram_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  ram_node #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_root (
    .clk_i  (clk_i),
    .we_i   (load_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o)
  );

  logic primed_q = 1'b0;
  always_ff @(posedge clk_i) primed_q <= 1'b1;

  assert_wr_visible_R5: assert property (@(posedge clk_i) disable iff (!primed_q)
    load_i |=> (addr_i != $past(addr_i)) || (rdata_o == $past(wdata_i)));

  assert_rd_hold_R3: assert property (@(posedge clk_i) disable iff (!primed_q)
    !load_i |=> !$stable(addr_i) || $stable(rdata_o));
endmodule

// File: tb/hier_ram_bench.sv
`timescale 1ns/1ps
module hier_ram_bench;
  localparam int unsigned AW    = 9;
  localparam int unsigned DW    = 16;
  localparam int unsigned WORDS = 1 << AW;
  localparam int unsigned LAST  = WORDS - 1;

  logic          clk = 1'b0;
  logic          load;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  hier_ram #(.ADDR_W(AW), .DATA_W(DW)) u_hier_ram (
    .clk_i  (clk),
    .load_i (load),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata)
  );

  typedef struct packed {
    logic          we;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          chk;
    logic [DW-1:0] exp;  // expected rdata before the edge
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 9'd0,   16'h1111, 1'b0, 16'h0000, 4'd2},
    '{1'b1, 9'd511, 16'hFFFF, 1'b0, 16'h0000, 4'd2},
    '{1'b0, 9'd0,   16'h0000, 1'b1, 16'h1111, 4'd2},  // R2 first word
    '{1'b0, 9'd511, 16'h0000, 1'b1, 16'hFFFF, 4'd2},  // R2 last word
    '{1'b1, 9'd0,   16'h2222, 1'b1, 16'h1111, 4'd5},  // R5 old value during write
    '{1'b0, 9'd0,   16'h0000, 1'b1, 16'h2222, 4'd5},  // R5 new value next cycle
    '{1'b1, 9'd64,  16'h0A0A, 1'b0, 16'h0000, 4'd7},
    '{1'b0, 9'd0,   16'h0000, 1'b1, 16'h2222, 4'd7},  // R7 selector bits only
    '{1'b0, 9'd64,  16'h0000, 1'b1, 16'h0A0A, 4'd7},
    '{1'b1, 9'd1,   16'h3333, 1'b0, 16'h0000, 4'd4},
    '{1'b0, 9'd0,   16'h0000, 1'b1, 16'h2222, 4'd4},  // R4 neighbour untouched
    '{1'b0, 9'd511, 16'h0000, 1'b1, 16'hFFFF, 4'd3},  // R3 load low, data ignored
    '{1'b0, 9'd511, 16'h1234, 1'b1, 16'hFFFF, 4'd3},  // R3
    '{1'b1, 9'd448, 16'h4444, 1'b0, 16'h0000, 4'd7},
    '{1'b0, 9'd511, 16'h0000, 1'b1, 16'hFFFF, 4'd7},  // R7 low bits only
    '{1'b0, 9'd448, 16'h0000, 1'b1, 16'h4444, 4'd7}
  };

  logic [DW-1:0] model [WORDS];
  logic [31:0]   lcg = 32'h1357_9BDF;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive after falling edge, settle, return before the rising edge
  task automatic apply(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    load  = we;
    addr  = a;
    wdata = d;
    #1;
  endtask

  function automatic logic [DW-1:0] pat(input int unsigned a);
    return DW'((a * 32'h9E37) ^ 32'hC3A5);
  endfunction

  initial begin
    load = 1'b0; addr = '0; wdata = '0;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].we, VECS[i].a, VECS[i].d);
      if (VECS[i].chk) chk($sformatf("R%0d vec%0d", VECS[i].req, i), rdata, VECS[i].exp);
    end

    // R1: fill every word with distinct data, then read back
    for (int a = 0; a < WORDS; a++) begin
      apply(1'b1, AW'(a), pat(a));
      model[a] = pat(a);
    end
    for (int a = 0; a < WORDS; a++) begin
      apply(1'b0, AW'(a), 16'hDEAD);
      chk("R1 readback", rdata, model[a]);
    end

    // R6: address changes within one cycle, no edge
    @(negedge clk);
    load = 1'b0;
    addr = AW'(5);   #1; chk("R6 addr 5",   rdata, model[5]);
    addr = AW'(LAST); #1; chk("R6 addr last", rdata, model[LAST]);
    addr = AW'(200); #1; chk("R6 addr 200", rdata, model[200]);

    // R4/R5/R2: random mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      logic          we;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      we  = lcg[7];
      a   = lcg[AW+8:9];
      if (lcg[4:2] == 3'd0) a = '0;
      if (lcg[4:2] == 3'd1) a = AW'(LAST);
      apply(we, a, lcg[31:16]);
      chk(we ? "R5 random write" : "R4 random read", rdata, model[a]);
      if (we) model[a] = lcg[31:16];
    end

    // R2: final boundary check after random phase
    apply(1'b0, '0, '0);          chk("R2 first", rdata, model[0]);
    apply(1'b0, AW'(LAST), '0);   chk("R2 last",  rdata, model[LAST]);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule